// File: doc/BRIEF.md
# Two-Wire Serial Bus Master

This block is the sole controller on a two-wire serial bus made of a clock line (SC) and a data line (SD). A host hands it one command at a time: open the bus with a start condition, close it with a stop condition, send a byte, or fetch a byte. The block turns each command into properly timed line activity and reports back with a one-cycle completion pulse, the received byte and an acknowledge status. Both lines are open-drain. The block only ever pulls a line low or lets it go, and it shows this through two output-enable signals.

Each bit slot is split into four quarter-phases of a parameterized length. SD only moves in the middle of the SC low time. A mode input, latched when a command is taken, picks one of two telegram formats. The acknowledged format has eight data bits plus a ninth handshake clock. The bare format has exactly eight clocks with no handshake slot. Bytes travel most significant bit first. When sending, the master listens in the ninth slot. When receiving, the master drives that slot itself.

Top module: `twb_master`

## Requirements
- R1: After reset `busy`, `done`, `nack`, `sc_oe` and `sd_oe` are all 0, so both lines are released. While the block stays idle, neither enable changes.
- R2: Command code 0 (start) makes SD go from high to low while SC is high. It then leaves SC and SD both pulled low (`sc_oe`=1, `sd_oe`=1).
- R3: Command code 1 (stop) makes SD go from low to high while SC is high. Afterwards both lines are released (`sc_oe`=0, `sd_oe`=0).
- R4: During a byte command SD never changes while SC is high, so no start or stop condition appears inside a telegram.
- R5: Command code 2 (write) puts `cmd_wdata` on SD most significant bit first, one bit per SC high pulse.
- R6: With `ack_en`=1 a byte command gives 9 SC high pulses. On a write, SD is released in the ninth slot and sampled at the SC rising edge. A sampled 1 sets `nack` to 1, a sampled 0 leaves it 0, and the command still completes with a `done` pulse.
- R7: Command code 3 (read) samples SD at each SC rising edge, most significant bit first. It presents the 8 bits on `rx_data` from the cycle in which `done` is high.
- R8: On a read with `ack_en`=1 the master drives the ninth slot itself. SD is pulled low when `cmd_rd_nack`=0 and left high when `cmd_rd_nack`=1.
- R9: With `ack_en`=0 a byte command gives exactly 8 SC high pulses with no handshake slot, and `nack` stays 0.
- R10: A command is taken only in a cycle where `cmd_valid`=1 and `busy`=0. A command presented while busy has no effect on the bus or on the results. A command held through the `done` cycle is taken at the next edge.
- R11: `busy` rises at the edge after acceptance and stays high for 4*QTR_CYCLES cycles per bit slot. `done` is high for exactly one cycle, in the cycle where `busy` has just fallen.
- R12: Accepting any command clears `nack` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write, 3 read |
| cmd_wdata | input | 8 | Byte to send on a write |
| cmd_rd_nack | input | 1 | On a read in acknowledged mode, leave the ninth slot high |
| ack_en | input | 1 | 1 selects the 9-clock acknowledged format, 0 the bare 8-clock format |
| sd_in | input | 1 | Resolved level of the SD line |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last byte received |
| nack | output | 1 | Receiver left the handshake slot high on the last write |
| sc_oe | output | 1 | 1 pulls SC low, 0 releases it |
| sd_oe | output | 1 | 1 pulls SD low, 0 releases it |

## Verification
Completion of one command and acceptance of the next can fall in the same cycle. `busy` is already low while `done` is high, so a request that is still asserted is taken at the very next edge. The bench provokes this by asserting a stop request while a write is still running and holding it unchanged. It then checks that the write finishes untouched, with all nine pulses and the sent bits intact. It also checks that `busy` rises again at the edge right after `done`, and that exactly one stop condition follows.

// File: rtl/twb_pkg.sv
package twb_pkg;

    localparam int unsigned TWB_DATA_BITS = 8;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } twb_op_e;

    typedef logic [1:0] twb_phase_t;

    // open-drain line enables: 1 pulls the line low
    typedef struct packed {
        logic sc_low;
        logic sd_low;
    } twb_lines_t;

    function automatic logic op_is_byte(twb_op_e op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

    // line enables on entry to quarter-phase ph of the given command
    function automatic twb_lines_t lines_for(twb_op_e op, twb_phase_t ph,
                                             logic pull, twb_lines_t cur);
        twb_lines_t r;
        r = cur;
        case (op)
            OP_START: begin
                case (ph)
                    2'd0:    r.sd_low = 1'b0;
                    2'd1:    begin r.sc_low = 1'b0; r.sd_low = 1'b0; end
                    2'd2:    r.sd_low = 1'b1;
                    default: r.sc_low = 1'b1;
                endcase
            end
            OP_STOP: begin
                case (ph)
                    2'd0:    r.sd_low = 1'b1;
                    2'd1:    r.sc_low = 1'b0;
                    2'd2:    r.sd_low = 1'b0;
                    default: r = cur;
                endcase
            end
            default: begin
                case (ph)
                    2'd0:    begin r.sc_low = 1'b1; r.sd_low = pull; end
                    2'd1:    r.sc_low = 1'b0;
                    2'd2:    r = cur;
                    default: r.sc_low = 1'b1;
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/twb_qtick.sv
module twb_qtick #(
    parameter int unsigned QTR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/twb_shreg.sv
module twb_shreg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign nxt[i] = shift_in;
        end else begin : g_up
            assign nxt[i] = q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/twb_master.sv
module twb_master
    import twb_pkg::*;
#(
    parameter int unsigned QTR_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [TWB_DATA_BITS-1:0] cmd_wdata,
    input  logic                     cmd_rd_nack,
    input  logic                     ack_en,
    input  logic                     sd_in,
    output logic                     busy,
    output logic                     done,
    output logic [TWB_DATA_BITS-1:0] rx_data,
    output logic                     nack,
    output logic                     sc_oe,
    output logic                     sd_oe
);
    localparam int unsigned BW = $clog2(TWB_DATA_BITS + 1);
    localparam logic [BW-1:0] ACK_IDX  = BW'(TWB_DATA_BITS);
    localparam logic [BW-1:0] LAST_DAT = BW'(TWB_DATA_BITS - 1);

    logic                     busy_q, done_q, ack_q, rdn_q, nack_q;
    twb_op_e                  op_q;
    twb_phase_t               ph_q;
    logic [BW-1:0]            bit_q;
    twb_lines_t               lines_q;
    logic [TWB_DATA_BITS-1:0] rx_q;

    logic                     ld, adv, tick, slot_end, finish, apply;
    logic                     rdn_n, tx_msb, pull, sample, data_sample, ack_sample;
    logic                     byte_op;
    twb_op_e                  op_n;
    twb_phase_t               ph_n;
    logic [BW-1:0]            bit_n, last_idx;
    twb_lines_t               lines_n;
    logic [TWB_DATA_BITS-1:0] sh_q;

    twb_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (busy_q),
        .restart (ld),
        .tick    (tick)
    );

    twb_shreg #(.W(TWB_DATA_BITS)) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (cmd_wdata),
        .shift    (data_sample),
        .shift_in (sd_in),
        .q        (sh_q)
    );

    always_comb begin
        ld       = cmd_valid && !busy_q;
        adv      = busy_q && tick;
        last_idx = ack_q ? ACK_IDX : LAST_DAT;
        slot_end = (ph_q == 2'd3);
        finish   = adv && slot_end && (!op_is_byte(op_q) || (bit_q == last_idx));
        apply    = ld || (adv && !finish);

        op_n  = ld ? twb_op_e'(cmd_op) : op_q;
        rdn_n = ld ? cmd_rd_nack : rdn_q;
        ph_n  = ph_q;
        bit_n = bit_q;
        if (ld) begin
            ph_n  = 2'd0;
            bit_n = '0;
        end else if (adv && !finish) begin
            if (slot_end) begin
                ph_n  = 2'd0;
                bit_n = bit_q + BW'(1);
            end else begin
                ph_n = ph_q + 2'd1;
            end
        end

        tx_msb = ld ? cmd_wdata[TWB_DATA_BITS-1] : sh_q[TWB_DATA_BITS-1];
        if (bit_n == ACK_IDX) begin
            pull = (op_n == OP_READ) && !rdn_n;
        end else begin
            pull = (op_n == OP_WRITE) && !tx_msb;
        end
        lines_n = lines_for(op_n, ph_n, pull, lines_q);

        sample      = adv && !finish && (ph_n == 2'd1) && op_is_byte(op_q);
        data_sample = sample && (bit_n != ACK_IDX);
        ack_sample  = sample && (bit_n == ACK_IDX) && (op_q == OP_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            op_q    <= OP_START;
            ack_q   <= 1'b0;
            rdn_q   <= 1'b0;
            ph_q    <= 2'd0;
            bit_q   <= '0;
            lines_q <= '0;
            rx_q    <= '0;
            nack_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (ld) begin
                busy_q <= 1'b1;
                op_q   <= op_n;
                ack_q  <= ack_en;
                rdn_q  <= cmd_rd_nack;
                nack_q <= 1'b0;
            end else if (finish) begin
                busy_q <= 1'b0;
            end
            ph_q  <= ph_n;
            bit_q <= bit_n;
            if (apply) begin
                lines_q <= lines_n;
            end
            if (ack_sample) begin
                nack_q <= sd_in;
            end
            if (finish && (op_q == OP_READ)) begin
                rx_q <= sh_q;
            end
        end
    end

    assign byte_op = busy_q && op_is_byte(op_q);
    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_data = rx_q;
    assign nack    = nack_q;
    assign sc_oe   = lines_q.sc_low;
    assign sd_oe   = lines_q.sd_low;

endmodule

// File: rtl/twb_master_chk.sv
module twb_master_chk (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic nack,
    input logic sc_oe,
    input logic sd_oe,
    input logic byte_op,
    input logic ack_lat
);
    // R1: enables stay put while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(sc_oe) && $stable(sd_oe)));

    // R4: SD holds across an SC high stretch inside a telegram
    p_sd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (byte_op && $past(byte_op) && !sc_oe && $past(!sc_oe)) |-> $stable(sd_oe));

    // R9: bare format never reports a refusal
    p_bare_no_nack_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack_lat) |-> !nack);

    // R10: an idle request is taken
    p_take_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> busy);

    // R11: completion pulse is a single cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: completion pulse marks the fall of busy
    p_done_on_fall_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R12: acceptance clears the status
    p_nack_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> !nack);
endmodule

bind twb_master twb_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .nack      (nack),
    .sc_oe     (sc_oe),
    .sd_oe     (sd_oe),
    .byte_op   (byte_op),
    .ack_lat   (ack_q)
);

// File: tb/twb_master_tb.sv
module twb_master_tb_top;
    localparam int unsigned QD = 4;
    localparam int NV = 8;
    // {mode, rd, data[7:0], slave_nack, rd_nack, exp_nack, pulses[3:0]}
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0, 4'd9},
        {1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b1, 4'd9},
        {1'b0, 1'b0, 8'h81, 1'b1, 1'b0, 1'b0, 4'd8},
        {1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 4'd9},
        {1'b1, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b0, 4'd9},
        {1'b0, 1'b1, 8'h7E, 1'b0, 1'b0, 1'b0, 4'd8},
        {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd9},
        {1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd9}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       cmd_rd_nack = 1'b0;
    logic       ack_en = 1'b1;
    logic       sd_in;
    logic       busy, done, nack, sc_oe, sd_oe;
    logic [7:0] rx_data;

    twb_master #(.QTR_CYCLES(QD)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_rd_nack(cmd_rd_nack), .ack_en(ack_en),
        .sd_in(sd_in), .busy(busy), .done(done), .rx_data(rx_data),
        .nack(nack), .sc_oe(sc_oe), .sd_oe(sd_oe)
    );

    // bus and slave model
    logic [8:0] slv_pat = 9'h1FF;
    int         fall_base = 0;
    int         fall_cnt = 0, rise_cnt = 0, start_cnt = 0, stop_cnt = 0;
    int         busy_cyc = 0, done_cyc = 0;
    logic [8:0] mon_bits = '0;
    logic       prev_sc = 1'b1, prev_sd = 1'b1;
    logic       sc_bus, sd_bus, slv_sd;
    int         slot;

    always_comb begin
        slot   = fall_cnt - fall_base;
        slv_sd = 1'b1;
        for (int k = 0; k < 9; k++) begin
            if (slot == k) slv_sd = slv_pat[8-k];
        end
        sc_bus = ~sc_oe;
        sd_bus = ~sd_oe & slv_sd;
        sd_in  = sd_bus;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_sc && !sc_bus) fall_cnt <= fall_cnt + 1;
            if (!prev_sc && sc_bus) begin
                rise_cnt <= rise_cnt + 1;
                mon_bits <= {mon_bits[7:0], sd_bus};
            end
            if (prev_sc && sc_bus && prev_sd && !sd_bus) start_cnt <= start_cnt + 1;
            if (prev_sc && sc_bus && !prev_sd && sd_bus) stop_cnt <= stop_cnt + 1;
            if (busy) busy_cyc <= busy_cyc + 1;
            if (done) done_cyc <= done_cyc + 1;
            prev_sc <= sc_bus;
            prev_sd <= sd_bus;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] d,
                         input logic rdn, input logic mode);
        step();
        cmd_valid   = 1'b1;
        cmd_op      = op;
        cmd_wdata   = d;
        cmd_rd_nack = rdn;
        ack_en      = mode;
        step();
        cmd_valid = 1'b0;
        while (!done) step();
    endtask

    task automatic do_start();
        int s0;
        s0 = start_cnt;
        issue(2'd0, 8'h00, 1'b0, 1'b1);
        step();
        chk(start_cnt - s0 == 1, "R2 start count", start_cnt - s0, 1);
        chk(sc_oe && sd_oe, "R2 lines low after start", {sc_oe, sd_oe}, 3);
    endtask

    task automatic do_stop();
        int p0;
        p0 = stop_cnt;
        issue(2'd1, 8'h00, 1'b0, 1'b1);
        chk(nack == 1'b0, "R12 nack cleared by next command", nack, 0);
        step();
        chk(stop_cnt - p0 == 1, "R3 stop count", stop_cnt - p0, 1);
        chk(!sc_oe && !sd_oe, "R3 lines released after stop", {sc_oe, sd_oe}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R11 actual=hang expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        step();
        // R1 reset state
        chk(!busy && !done && !nack, "R1 status after reset", {busy, done, nack}, 0);
        chk(!sc_oe && !sd_oe, "R1 lines released after reset", {sc_oe, sd_oe}, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic       mode, rd, sn, rn, en;
            logic [7:0] d;
            int         pulses, r0, s0, p0;
            mode   = VEC[v][16];
            rd     = VEC[v][15];
            d      = VEC[v][14:7];
            sn     = VEC[v][6];
            rn     = VEC[v][5];
            en     = VEC[v][4];
            pulses = int'(VEC[v][3:0]);
            do_start();
            slv_pat   = rd ? {d, 1'b1} : {8'hFF, sn};
            fall_base = fall_cnt;
            r0 = rise_cnt; s0 = start_cnt; p0 = stop_cnt;
            issue(rd ? 2'd3 : 2'd2, d, rn, mode);
            chk(rise_cnt - r0 == pulses, mode ? "R6 nine clocks" : "R9 eight clocks",
                rise_cnt - r0, pulses);
            chk(start_cnt == s0 && stop_cnt == p0, "R4 no condition inside telegram",
                start_cnt - s0 + stop_cnt - p0, 0);
            chk(nack == en, mode ? "R6 nack status" : "R9 nack stays low", nack, en);
            if (!rd) begin
                logic [7:0] seen;
                seen = mode ? mon_bits[8:1] : mon_bits[7:0];
                chk(seen == d, "R5 bits on bus msb first", seen, d);
            end else begin
                chk(rx_data == d, "R7 received byte", rx_data, d);
                if (mode) chk(mon_bits[0] == rn, "R8 master ack slot", mon_bits[0], rn);
            end
            do_stop();
        end

        // R10/R11: request held through a running write, taken after done
        begin
            int r0, p0, b0, d0;
            do_start();
            slv_pat   = {8'hFF, 1'b0};
            fall_base = fall_cnt;
            r0 = rise_cnt; p0 = stop_cnt; b0 = busy_cyc; d0 = done_cyc;
            step();
            cmd_valid = 1'b1; cmd_op = 2'd2; cmd_wdata = 8'h96; ack_en = 1'b1;
            step();
            cmd_op = 2'd1; cmd_wdata = 8'h00; ack_en = 1'b0;
            while (!done) step();
            chk(busy_cyc - b0 == 36 * QD, "R11 busy length", busy_cyc - b0, 36 * QD);
            chk(rise_cnt - r0 == 9, "R10 write untouched pulses", rise_cnt - r0, 9);
            chk(mon_bits[8:1] == 8'h96, "R10 write untouched data", mon_bits[8:1], 8'h96);
            chk(stop_cnt == p0, "R10 no stop while busy", stop_cnt - p0, 0);
            step();
            chk(busy && !done, "R10 held request taken after done", {busy, done}, 2);
            cmd_valid = 1'b0;
            while (!done) step();
            step();
            chk(!done, "R11 done one cycle", done, 0);
            chk(done_cyc - d0 == 2, "R11 done pulses", done_cyc - d0, 2);
            chk(stop_cnt - p0 == 1, "R3 stop after back-to-back", stop_cnt - p0, 1);
            chk(!sc_oe && !sd_oe, "R1 lines idle at end", {sc_oe, sd_oe}, 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule